// File: doc/BRIEF.md
# Streaming Transposed IIR Filter

This block is a fixed-point infinite impulse response filter built in transposed direct-form II. Each accepted input sample is sent to every tap at once. Every tap is a multiply-accumulate stage that holds one state register. The output sample is formed at the head of the chain from the leading feedforward coefficient and the first state. The filter order, the data width, the coefficient width and the coefficient fraction width are all compile-time parameters.

Samples enter and leave on valid/ready streams, and both streams run on one clock. A separate write-port block owns the coefficient register bank, and the filter reads that bank through two flat buses. The leading feedback coefficient is fixed at one, so it has no port. Products are formed at full precision and summed in a wide accumulator. At the output, the accumulator is scaled down by the fraction width and clamped to the data range. When the output is held back by backpressure, the whole filter stalls.

Top module: `iir_stream_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `in_ready` and `out_valid` are low. Reset also clears `out_data` and every tap state to zero.
- R2: A sample is accepted only in a cycle where `in_valid` and `in_ready` are both high. Each accepted sample raises `out_valid` in the following cycle, and yields exactly one output sample.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` stays low, `out_valid` stays high and `out_data` is held. The tap states also stay unchanged.
- R4: The head accumulator is computed as `acc = b0*x + s1`, with products at full precision and a width of ACC_W = DATA_W+COEF_W+GUARD_W. The output is `y = sat(acc >>> FRAC_W)`, where the shift is arithmetic and rounds toward minus infinity.
- R5: On each accepted sample, tap k (k = 1..ORDER) loads `s_k = b_k*x - a_k*y + s_(k+1)`, where the state above the last tap is taken as zero. The leading feedback coefficient is an implied 1 and is never multiplied.
- R6: Saturation clamps the scaled value to the range -2^(DATA_W-1) .. 2^(DATA_W-1)-1.
- R7: Coefficients are sampled only in the cycle a sample is accepted. Changing them while an output is pending does not alter that output.
- R8: All accumulator and state arithmetic wraps in two's complement at ACC_W bits.
- R9: Coefficient bus layout: `coef_b` holds b_k at bits [k*COEF_W +: COEF_W] for k = 0..ORDER. `coef_a` holds a_k at bits [(k-1)*COEF_W +: COEF_W] for k = 1..ORDER. All coefficients are signed two's complement with FRAC_W fraction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both streams |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Filter can accept a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Downstream consumer takes the output |
| out_data | output | DATA_W | Signed filtered sample |
| coef_b | input | (ORDER+1)*COEF_W | Feedforward coefficients b0..bORDER |
| coef_a | input | ORDER*COEF_W | Feedback coefficients a1..aORDER |

## Verification
A sample accepted at a rising edge produces its result in `out_data` and `out_valid` right after that edge. The state it writes affects only the next accepted sample. The bench drives and samples at the falling edge. At that point it decides whether a transfer happens on the coming rising edge, and it steps its reference model only for those transfers. It then compares the single pending result when the output handshake completes, so a stalled result is compared against the value captured at its own acceptance.

// File: rtl/iir_pkg.sv
package iir_pkg;
  typedef enum logic [0:0] {
    FLOW_INIT = 1'b0,
    FLOW_RUN  = 1'b1
  } flow_state_t;
endpackage

// File: rtl/iir_flow.sv
module iir_flow
  import iir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic in_fire,
  output logic out_valid
);
  flow_state_t state_q;

  assign in_ready = (state_q == FLOW_RUN) && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FLOW_INIT;
      out_valid <= 1'b0;
    end else begin
      state_q <= FLOW_RUN;
      if (in_fire) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R1: no handshake during reset or the cycle after it
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

  // R2: an accepted sample gives a valid output next cycle
  a_r2_fire_gives_valid: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> out_valid);

  // R3: stall blocks input and keeps output valid
  a_r3_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  a_r3_stall_keeps_valid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/iir_tap.sv
module iir_tap #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] y,
  input  logic signed [COEF_W-1:0] b,
  input  logic signed [COEF_W-1:0] a,
  input  logic signed [ACC_W-1:0]  upper,
  output logic signed [ACC_W-1:0]  state
);
  logic signed [ACC_W-1:0] xe, ye, be, ae, bx, ay, nxt;

  assign xe  = {{(ACC_W-DATA_W){x[DATA_W-1]}}, x};
  assign ye  = {{(ACC_W-DATA_W){y[DATA_W-1]}}, y};
  assign be  = {{(ACC_W-COEF_W){b[COEF_W-1]}}, b};
  assign ae  = {{(ACC_W-COEF_W){a[COEF_W-1]}}, a};
  assign bx  = xe * be;
  assign ay  = ye * ae;
  assign nxt = bx - ay + upper;

  always_ff @(posedge clk) begin
    if (rst)     state <= '0;
    else if (en) state <= nxt;
  end

  // R3: state is frozen whenever no sample is accepted
  a_r3_state_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  // R1: reset clears the state
  a_r1_state_cleared: assert property (@(posedge clk)
    rst |=> (state == '0));
endmodule

// File: rtl/iir_stream_filter.sv
module iir_stream_filter #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int ORDER   = 2,
  parameter int GUARD_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic signed [DATA_W-1:0]      in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic signed [DATA_W-1:0]      out_data,
  input  logic [(ORDER+1)*COEF_W-1:0]   coef_b,
  input  logic [ORDER*COEF_W-1:0]       coef_a
);
  localparam int ACC_W = DATA_W + COEF_W + GUARD_W;
  localparam logic signed [ACC_W-1:0] MAX_A =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_A =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  // Scale down by the fraction width and clamp to the data range.
  function automatic logic signed [DATA_W-1:0] scale_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] sh;
    sh = acc >>> FRAC_W;
    if (sh > MAX_A)      sh = MAX_A;
    else if (sh < MIN_A) sh = MIN_A;
    return sh[DATA_W-1:0];
  endfunction

  logic                     in_fire;
  logic signed [ACC_W-1:0]  st [1:ORDER+1];
  logic signed [ACC_W-1:0]  xe, b0e, head_acc;
  logic signed [DATA_W-1:0] y_new;
  logic signed [COEF_W-1:0] b0;

  iir_flow u_flow (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .in_fire   (in_fire),
    .out_valid (out_valid)
  );

  assign b0       = coef_b[COEF_W-1:0];
  assign xe       = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
  assign b0e      = {{(ACC_W-COEF_W){b0[COEF_W-1]}}, b0};
  assign head_acc = xe * b0e + st[1];
  assign y_new    = scale_sat(head_acc);

  assign st[ORDER+1] = '0;

  for (genvar k = 1; k <= ORDER; k++) begin : g_tap
    iir_tap #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) u_tap (
      .clk   (clk),
      .rst   (rst),
      .en    (in_fire),
      .x     (in_data),
      .y     (y_new),
      .b     (coef_b[k*COEF_W +: COEF_W]),
      .a     (coef_a[(k-1)*COEF_W +: COEF_W]),
      .upper (st[k+1]),
      .state (st[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          out_data <= '0;
    else if (in_fire) out_data <= y_new;
  end

  // R3: output data held during a stall
  a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7: output changes only on an accepted sample
  a_r7_data_only_on_fire: assert property (@(posedge clk) disable iff (rst)
    !in_fire |=> $stable(out_data));

  // R1: reset clears output data
  a_r1_data_cleared: assert property (@(posedge clk)
    rst |=> (out_data == '0));
endmodule

// File: tb/iir_stream_filter_tb.sv
module iir_stream_filter_tb;
  localparam int DW = 16, CW = 16, FW = 14, ORD = 2, GW = 4;
  localparam int AW = DW + CW + GW;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_data = '0;
  logic signed [DW-1:0] out_data;
  logic [(ORD+1)*CW-1:0] coef_b = '0;
  logic [ORD*CW-1:0]     coef_a = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iir_stream_filter #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FW), .ORDER(ORD), .GUARD_W(GW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .coef_b(coef_b), .coef_a(coef_a));

  longint s [1:ORD+1];
  bit     have_exp = 0;
  longint exp_y = 0;
  bit     prev_stall = 0;
  longint prev_data = 0;

  function automatic longint wrapv(longint v);
    return (v <<< (64 - AW)) >>> (64 - AW);
  endfunction

  function automatic longint clampv(longint acc);
    longint sh = acc >>> FW;
    longint hi = (64'sd1 <<< (DW - 1)) - 1;
    longint lo = -(64'sd1 <<< (DW - 1));
    if (sh > hi) return hi;
    if (sh < lo) return lo;
    return sh;
  endfunction

  function automatic longint cb(int k);
    return longint'($signed(coef_b[k*CW +: CW]));
  endfunction

  function automatic longint ca(int k);
    return longint'($signed(coef_a[(k-1)*CW +: CW]));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Reference step for one accepted sample (R4, R5, R6, R8, R9).
  task automatic model_step(input longint x);
    longint acc, y;
    acc = wrapv(cb(0) * x + s[1]);
    y = clampv(acc);
    for (int k = 1; k <= ORD; k++) s[k] = wrapv(cb(k) * x - ca(k) * y + s[k+1]);
    exp_y = y;
    have_exp = 1;
  endtask

  task automatic set_coefs(input int mode);
    if (mode == 0) begin
      coef_b = {16'sd4096, 16'sd8192, 16'sd4096};
      coef_a = {16'sd2048, -16'sd8192};
    end else if (mode == 1) begin
      coef_b = {16'($urandom_range(0, 4000)), 16'($urandom_range(0, 4000)), 16'sd32767};
      coef_a = {16'($urandom_range(0, 2000)), 16'($urandom_range(0, 2000))};
    end else begin
      coef_b = {16'($urandom), 16'($urandom), 16'($urandom)};
      coef_a = {16'($urandom), 16'($urandom)};
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 1; k <= ORD + 1; k++) s[k] = 0;
    set_coefs(0);
    in_valid = 1'b1;
    in_data = 16'sd1000;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet during reset even with valid input
    chk(!in_ready, "R1 in_ready in reset", in_ready, 0);
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    chk(out_data == 0, "R1 out_data in reset", out_data, 0);
    rst = 1'b0;
    #1;
    chk(!in_ready, "R1 in_ready first cycle after reset", in_ready, 0);
    in_valid = 1'b0;

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (c < 1000) set_coefs(0);
      else if (c < 2000) set_coefs(1);
      else set_coefs(2);
      if (c < 1000) in_data = DW'($signed($urandom_range(0, 4000)) - 2000);
      else in_data = DW'($urandom);
      if (c == 5) in_data = 16'sd16000;
      in_valid  = ($urandom_range(0, 9) < 7);
      out_ready = ($urandom_range(0, 9) < ((c >= 1000 && c < 2000) ? 3 : 7));
      #1;
      // R2: output valid exactly when one result is pending
      chk(out_valid == have_exp, "R2 out_valid vs pending", out_valid, have_exp);
      // R3: held data and blocked input while stalled
      if (prev_stall) chk(out_data == prev_data, "R3 data held in stall", out_data, prev_data);
      if (out_valid && !out_ready) chk(!in_ready, "R3 in_ready low in stall", in_ready, 0);
      // R4/R6/R7/R8: pending result matches model at its own acceptance
      if (out_valid && out_ready && have_exp) begin
        chk(longint'(out_data) == exp_y, "R4 R5 R6 R7 R8 output value", out_data, exp_y);
        have_exp = 0;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_valid && in_ready) model_step(longint'(in_data));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule